// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block merges two groups of interrupt sources into one active-low global interrupt pin and two dedicated interrupt-line pins. The first group is the embedded protocol controller. Its event pulses set sticky bits in a controller status word. Each of those bits has an enable bit and a line-select bit, and each of the two lines has its own gate. The outputs of the two gated lines are ORed into a live summary bit of the device status word. The device status word also holds sticky device-level flags, and a device enable word masks every bit of it. The global pin is low while any unmasked device status bit is set, including the live summary bit.

A bus-silence timer counts clock cycles since the last transmitted or received frame. When the count reaches its limit, the timer sets a silence flag together with the CAN-error and global-error flags. A simple word-addressed port reads and writes the registers. Reads are combinational on `addr`. Writes take effect at the clock edge.

Register words:
- word 0: device status.
- word 1: read-only copy of the controller status. It sits directly after the device status, so a two-word burst returns both.
- word 2: device enable.
- word 3: controller status.
- word 4: controller enable.
- word 5: line select.
- word 6: line gate, bits 1:0.
- word 7: reads zero.

Top module: `intagg_top`

## Requirements
- R1: While reset is applied and directly after it, `int_n`, `line0_n` and `line1_n` are high. Word 2 reads all ones, and every other word reads zero.
- R2: A 1 on `ctrl_evt[i]` sets controller status bit i at the next edge.
  - Writing 1 to bit i of word 3 clears that bit. Writing 0 to bit i leaves it unchanged.
  - If an event and a clear for the same bit arrive in the same cycle, the bit stays set.
- R3: Controller bit i drives line k only when all of the following hold: its enable bit (word 4) is 1, its select bit (word 5) equals k, and line gate bit k (word 6) is 1.
  - `line0_n` is low exactly while line 0 is driven, and `line1_n` is low exactly while line 1 is driven.
- R4: With word 6 equal to 0, set controller status bits cannot pull `int_n`, `line0_n` or `line1_n` low, and they cannot set the summary bit. Word 1 still shows the raw controller status.
- R5: Device status bit 1 is a live summary equal to (line 0 driven OR line 1 driven). Writes and `dev_evt[1]` have no effect on it.
- R6: `int_n` is low exactly while the AND of device status (word 0) and device enable (word 2) is nonzero.
- R7: Word 1 always reads the same value as word 3. Writes to word 1 change no register.
- R8: Once `SILENCE_CYCLES` edges have passed without `frame_evt` since the last frame (or since reset), device status bits 10, 5 and 7 are set. A `frame_evt` restarts the count.
- R9: Device enable resets to all ones. With bit 10 of word 2 cleared, the silence flag alone does not pull `int_n` low.
- R10: `dev_evt[j]` sets device status bit j (for j not 1). Writing 1 to bit j of word 0 clears that bit. A set and a clear in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_evt | input | DATA_W | Controller event pulses, one per status bit |
| dev_evt | input | DATA_W | Device-level event pulses |
| frame_evt | input | 1 | Pulse on every transmitted or received frame |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| int_n | output | 1 | Global interrupt, active low |
| line0_n | output | 1 | Dedicated line 0 interrupt, active low |
| line1_n | output | 1 | Dedicated line 1 interrupt, active low |

## Verification
The bench builds the block with `DATA_W` = 32 and `SILENCE_CYCLES` = 24. With this short timeout the silence flag and its two companion flags fire many times during random traffic, and the exact expiry edge can be probed directly around a frame pulse. The full 32-bit width exercises clears, enables and line selects at every bit position. A directed sweep covers all 16 combinations of enable, select and line gate for one controller bit.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  typedef enum logic [2:0] {
    REG_DEV_STAT    = 3'd0,
    REG_CTRL_MIRROR = 3'd1,
    REG_DEV_EN      = 3'd2,
    REG_CTRL_STAT   = 3'd3,
    REG_CTRL_EN     = 3'd4,
    REG_CTRL_SEL    = 3'd5,
    REG_LINE_EN     = 3'd6
  } reg_addr_e;

  localparam int unsigned BIT_CTRL_SUM = 1;
  localparam int unsigned BIT_CAN_ERR  = 5;
  localparam int unsigned BIT_GLB_ERR  = 7;
  localparam int unsigned BIT_SILENCE  = 10;
  localparam int unsigned NUM_LINES    = 2;

  // Sticky update: clear on write-1, set wins over clear
  function automatic logic [63:0] sticky_next(input logic [63:0] cur,
                                              input logic [63:0] clr,
                                              input logic [63:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Mask of bits whose select matches line k
  function automatic logic [63:0] line_pick(input logic [63:0] sel, input int unsigned k);
    return (k == 0) ? ~sel : sel;
  endfunction
endpackage

// File: rtl/intagg_sticky.sv
module intagg_sticky #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  import intagg_pkg::*;
  logic [63:0] nxt;
  assign nxt = sticky_next(64'(q), 64'(clr), 64'(set));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
  end
endmodule

// File: rtl/intagg_cfg.sv
module intagg_cfg #(
  parameter int unsigned W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= d;
  end
endmodule

// File: rtl/intagg_silence.sv
module intagg_silence #(
  parameter int unsigned CYCLES = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  output logic expire
);
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  assign expire = !frame && (cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (frame || expire) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/intagg_route.sv
module intagg_route #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] stat,
  input  logic [W-1:0] en,
  input  logic [W-1:0] sel,
  input  logic [1:0]   gate,
  output logic [1:0]   line_act
);
  import intagg_pkg::*;
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic [63:0] pick;
    assign pick        = line_pick(64'(sel), k);
    assign line_act[k] = gate[k] && |(stat & en & pick[W-1:0]);
  end
endmodule

// File: rtl/intagg_top.sv
module intagg_top #(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned SILENCE_CYCLES = 250_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ctrl_evt,
  input  logic [DATA_W-1:0] dev_evt,
  input  logic              frame_evt,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              int_n,
  output logic              line0_n,
  output logic              line1_n
);
  import intagg_pkg::*;

  localparam logic [DATA_W-1:0] SUM_MASK = DATA_W'(1) << BIT_CTRL_SUM;
  localparam logic [DATA_W-1:0] SIL_SET  = (DATA_W'(1) << BIT_SILENCE)
                                         | (DATA_W'(1) << BIT_CAN_ERR)
                                         | (DATA_W'(1) << BIT_GLB_ERR);

  logic [DATA_W-1:0] ctrl_stat, ctrl_en, ctrl_sel, dev_stat, dev_en, dev_view;
  logic [DATA_W-1:0] ctrl_clr, dev_clr, dev_set;
  logic [1:0]        line_en, line_act;
  logic              silence_hit, summary;
  logic              we_ctrl_stat, we_dev_stat, we_dev_en, we_ctrl_en, we_ctrl_sel, we_line_en;

  assign we_ctrl_stat = wr_en && (addr == REG_CTRL_STAT);
  assign we_dev_stat  = wr_en && (addr == REG_DEV_STAT);
  assign we_dev_en    = wr_en && (addr == REG_DEV_EN);
  assign we_ctrl_en   = wr_en && (addr == REG_CTRL_EN);
  assign we_ctrl_sel  = wr_en && (addr == REG_CTRL_SEL);
  assign we_line_en   = wr_en && (addr == REG_LINE_EN);

  assign ctrl_clr = we_ctrl_stat ? wr_data : '0;
  assign dev_clr  = we_dev_stat ? (wr_data & ~SUM_MASK) : '0;
  assign dev_set  = (dev_evt & ~SUM_MASK) | (silence_hit ? SIL_SET : '0);

  intagg_sticky #(.W(DATA_W)) u_ctrl_stat (
    .clk(clk), .rst_n(rst_n), .set(ctrl_evt), .clr(ctrl_clr), .q(ctrl_stat));

  intagg_sticky #(.W(DATA_W)) u_dev_stat (
    .clk(clk), .rst_n(rst_n), .set(dev_set), .clr(dev_clr), .q(dev_stat));

  intagg_cfg #(.W(DATA_W), .RST_VAL('1)) u_dev_en (
    .clk(clk), .rst_n(rst_n), .we(we_dev_en), .d(wr_data), .q(dev_en));

  intagg_cfg #(.W(DATA_W), .RST_VAL('0)) u_ctrl_en (
    .clk(clk), .rst_n(rst_n), .we(we_ctrl_en), .d(wr_data), .q(ctrl_en));

  intagg_cfg #(.W(DATA_W), .RST_VAL('0)) u_ctrl_sel (
    .clk(clk), .rst_n(rst_n), .we(we_ctrl_sel), .d(wr_data), .q(ctrl_sel));

  intagg_cfg #(.W(2), .RST_VAL(2'b00)) u_line_en (
    .clk(clk), .rst_n(rst_n), .we(we_line_en), .d(wr_data[1:0]), .q(line_en));

  intagg_silence #(.CYCLES(SILENCE_CYCLES)) u_silence (
    .clk(clk), .rst_n(rst_n), .frame(frame_evt), .expire(silence_hit));

  intagg_route #(.W(DATA_W)) u_route (
    .stat(ctrl_stat), .en(ctrl_en), .sel(ctrl_sel), .gate(line_en), .line_act(line_act));

  assign summary  = |line_act;
  assign dev_view = dev_stat | (summary ? SUM_MASK : '0);
  assign int_n    = !(|(dev_view & dev_en));
  assign line0_n  = !line_act[0];
  assign line1_n  = !line_act[1];

  always_comb begin
    case (addr)
      REG_DEV_STAT:    rd_data = dev_view;
      REG_CTRL_MIRROR: rd_data = ctrl_stat;
      REG_DEV_EN:      rd_data = dev_en;
      REG_CTRL_STAT:   rd_data = ctrl_stat;
      REG_CTRL_EN:     rd_data = ctrl_en;
      REG_CTRL_SEL:    rd_data = ctrl_sel;
      REG_LINE_EN:     rd_data = DATA_W'(line_en);
      default:         rd_data = '0;
    endcase
  end
endmodule

// File: rtl/intagg_checker.sv
module intagg_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ctrl_evt,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ctrl_stat,
  input logic [DATA_W-1:0] dev_stat,
  input logic [1:0]        line_en,
  input logic              summary,
  input logic              line0_n,
  input logic              line1_n,
  input logic              silence_hit,
  input logic              frame_evt
);
  import intagg_pkg::*;

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_evt != '0) |=> ((ctrl_stat & $past(ctrl_evt)) == $past(ctrl_evt)));

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_CTRL_STAT && ctrl_evt == '0) |=> ((ctrl_stat & $past(wr_data)) == '0));

  assert_lines_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en == 2'b00) |-> (line0_n && line1_n && !summary));

  assert_summary_needs_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    summary |-> (ctrl_stat != '0));

  assert_silence_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    silence_hit |=> (dev_stat[BIT_SILENCE] && dev_stat[BIT_CAN_ERR] && dev_stat[BIT_GLB_ERR]));

  assert_frame_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> !silence_hit);
endmodule

bind intagg_top intagg_checker #(.DATA_W(DATA_W)) u_intagg_checker (
  .clk(clk), .rst_n(rst_n), .ctrl_evt(ctrl_evt), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .ctrl_stat(ctrl_stat), .dev_stat(dev_stat), .line_en(line_en),
  .summary(summary), .line0_n(line0_n), .line1_n(line1_n),
  .silence_hit(silence_hit), .frame_evt(frame_evt));

// File: tb/tb_intagg_top.sv
`timescale 1ns/1ps
module tb_intagg_top;
  localparam int unsigned DW = 32;
  localparam int unsigned SIL = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] ctrl_evt = '0, dev_evt = '0, wr_data = '0;
  logic          frame_evt = 1'b0, wr_en = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [DW-1:0] rd_data;
  logic          int_n, line0_n, line1_n;

  intagg_top #(.DATA_W(DW), .SILENCE_CYCLES(SIL)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_evt(ctrl_evt), .dev_evt(dev_evt),
    .frame_evt(frame_evt), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .int_n(int_n), .line0_n(line0_n), .line1_n(line1_n));

  always #2 clk = ~clk;

  int unsigned n_total = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] m_cstat, m_cen, m_csel, m_dstat, m_den;
  logic [1:0]    m_len;
  int unsigned   m_cnt;

  function automatic logic [DW-1:0] b(input int unsigned i);
    return DW'(1) << i;
  endfunction

  function automatic logic exp_line(input int unsigned k);
    logic [DW-1:0] pick;
    pick = (k == 0) ? ~m_csel : m_csel;
    return m_len[k] && ((m_cstat & m_cen & pick) != '0);
  endfunction

  function automatic logic [DW-1:0] exp_dview();
    return m_dstat | ((exp_line(0) || exp_line(1)) ? b(1) : '0);
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return exp_dview();
      3'd1: return m_cstat;
      3'd2: return m_den;
      3'd3: return m_cstat;
      3'd4: return m_cen;
      3'd5: return m_csel;
      3'd6: return DW'(m_len);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cstat = '0; m_cen = '0; m_csel = '0; m_dstat = '0; m_den = '1; m_len = 2'b00; m_cnt = 0;
  endtask

  task automatic compare(input string tag);
    chk({tag, " int_n"}, DW'(int_n), DW'(!((exp_dview() & m_den) != '0)));
    chk({tag, " line0_n"}, DW'(line0_n), DW'(!exp_line(0)));
    chk({tag, " line1_n"}, DW'(line1_n), DW'(!exp_line(1)));
    chk({tag, " rd_data"}, rd_data, exp_rd(addr));
  endtask

  // one clock: model next state from driven inputs, then sample at negedge
  task automatic step(input string tag);
    logic hit;
    logic [DW-1:0] cclr, dclr;
    hit  = !frame_evt && (m_cnt == SIL - 1);
    cclr = (wr_en && addr == 3'd3) ? wr_data : '0;
    dclr = (wr_en && addr == 3'd0) ? (wr_data & ~b(1)) : '0;
    @(posedge clk);
    m_cnt   = (frame_evt || hit) ? 0 : m_cnt + 1;
    m_cstat = (m_cstat & ~cclr) | ctrl_evt;
    m_dstat = (m_dstat & ~dclr) | (dev_evt & ~b(1)) | (hit ? (b(10) | b(5) | b(7)) : '0);
    if (wr_en && addr == 3'd2) m_den  = wr_data;
    if (wr_en && addr == 3'd4) m_cen  = wr_data;
    if (wr_en && addr == 3'd5) m_csel = wr_data;
    if (wr_en && addr == 3'd6) m_len  = wr_data[1:0];
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    ctrl_evt = '0; dev_evt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input string tag);
    addr = a; wr_en = 1'b1; wr_data = d; step(tag); wr_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        n_total++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 int_n", DW'(int_n), DW'(1));
    chk("R1 line0_n", DW'(line0_n), DW'(1));
    chk("R1 line1_n", DW'(line1_n), DW'(1));
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #0.1;
      chk("R1 rd_data", rd_data, (a == 2) ? '1 : '0);
    end
    rst_n = 1'b1;
    frame_evt = 1'b1;
    addr = 3'd0;
    step("R1");

    // R2: event set, write-0 no effect, write-1 clear, set wins over clear
    ctrl_evt = b(3) | b(20); addr = 3'd3; step("R2 set"); idle();
    chk("R2 set bits", rd_data, b(3) | b(20));
    wr(3'd3, '0, "R2 write0");
    chk("R2 write0 keeps", rd_data, b(3) | b(20));
    wr(3'd3, b(3), "R2 clr");
    chk("R2 cleared", rd_data, b(20));
    ctrl_evt = b(20); wr(3'd3, b(20), "R2 set-wins"); idle();
    chk("R2 set wins", rd_data, b(20));
    wr(3'd3, '1, "R2 clr all");

    // R3/R4/R5/R6: sweep enable x select x line gate for bit 3
    for (int c = 0; c < 16; c++) begin
      wr(3'd4, (c & 1) ? b(3) : '0, "R3 en");
      wr(3'd5, (c & 2) ? b(3) : '0, "R3 sel");
      wr(3'd6, DW'(c >> 2), "R3 gate");
      ctrl_evt = b(3); addr = 3'd0; step("R3 evt"); idle();
      chk("R3 line0_n", DW'(line0_n), DW'(!((c & 1) && !(c & 2) && ((c >> 2) & 1))));
      chk("R3 line1_n", DW'(line1_n), DW'(!((c & 1) && (c & 2) && ((c >> 3) & 1))));
      chk("R5 summary", rd_data & b(1), (!line0_n || !line1_n) ? b(1) : '0);
      if ((c >> 2) == 0) begin
        chk("R4 int_n", DW'(int_n), DW'(1));
        addr = 3'd1; #0.1;
        chk("R4 mirror raw", rd_data, b(3));
      end
      wr(3'd3, '1, "R3 clr");
      chk("R6 int_n idle", DW'(int_n), DW'(1));
    end

    // R5: summary bit immune to write and dev_evt[1]
    wr(3'd4, b(0), "R5"); wr(3'd6, 2'b01, "R5");
    dev_evt = b(1); step("R5 devevt"); idle();
    addr = 3'd0; #0.1;
    chk("R5 no devevt", rd_data, '0);
    ctrl_evt = b(0); step("R5"); idle();
    wr(3'd0, b(1), "R5 w1 summary");
    chk("R5 summary kept", rd_data & b(1), b(1));
    wr(3'd3, '1, "R5 clr");
    addr = 3'd0; #0.1;
    chk("R5 summary drop", rd_data, '0);

    // R7: mirror write ignored
    ctrl_evt = b(9); step("R7"); idle();
    wr(3'd1, '1, "R7 wr mirror");
    addr = 3'd1; #0.1;
    chk("R7 mirror", rd_data, b(9));
    wr(3'd3, '1, "R7 clr");

    // R8: silence expiry edge
    frame_evt = 1'b1; addr = 3'd0; step("R8 frame"); frame_evt = 1'b0;
    for (int i = 0; i < SIL - 1; i++) step("R8 wait");
    chk("R8 not yet", rd_data & b(10), '0);
    step("R8 hit");
    chk("R8 flags", rd_data & (b(10) | b(5) | b(7)), b(10) | b(5) | b(7));
    chk("R8 int_n", DW'(int_n), DW'(0));
    frame_evt = 1'b1;

    // R9: mask silence plus its companions
    wr(3'd2, ~(b(10) | b(5) | b(7)), "R9 mask");
    wr(3'd0, '1, "R9 clr");
    frame_evt = 1'b0;
    for (int i = 0; i < SIL + 2; i++) step("R9 wait");
    chk("R9 flag set", rd_data & b(10), b(10));
    chk("R9 int_n masked", DW'(int_n), DW'(1));
    wr(3'd2, ~b(10), "R9 only10");
    chk("R9 companions low", DW'(int_n), DW'(0));
    frame_evt = 1'b1;

    // R10: device status set/clear
    wr(3'd0, '1, "R10 clr");
    dev_evt = b(14); wr(3'd0, b(14), "R10 set-wins"); idle();
    addr = 3'd0; #0.1;
    chk("R10 set wins", rd_data, b(14));
    wr(3'd0, b(14), "R10 clr");
    chk("R10 cleared", rd_data, '0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      ctrl_evt  = $urandom & $urandom & $urandom & $urandom;
      dev_evt   = $urandom & $urandom & $urandom & $urandom & $urandom;
      frame_evt = ($urandom % 8) == 0;
      wr_en     = ($urandom % 3) == 0;
      addr      = 3'($urandom);
      wr_data   = ($urandom % 2) ? $urandom : ($urandom & $urandom);
      step("R3/R6/R10 random");
    end
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule